// File: doc/BRIEF.md
# Synchronous Serial Word Port

This block is the data path of a synchronous serial port that software sees as a single 16-bit data word. Words written by the bus go into an 8-entry transmit FIFO. A frame engine takes one word at a time from that FIFO, loads it into a shift register and sends it out most significant bit first, one bit per pulse of an external bit-rate tick. Bits arriving on the serial input are gathered into a word of the programmed size and pushed into an 8-entry receive FIFO, which the bus drains one word per read.

The frame size can be set from 4 to 16 bits. Short words are right-justified on both sides: unused upper bits of a written word are never sent, and a received short word lands in the low bits with zeros above. A three-wire command mode changes the frame into two halves: an 8-bit command taken from the low byte of the written word goes out first, then the programmed number of bits is received while the output stays low. Clearing the enable stops new frames from starting but leaves both FIFOs intact, so software can load the transmit FIFO before turning the port on.

The write side is a valid/ready stream with no back-pressure holding: `wr_ready` is high while the transmit FIFO has room, and a word offered with `wr_valid` while `wr_ready` is low is lost, not held. The read side is a request strobe that pops the head word shown on `rd_data`.

Top module: `ser_word_port`

## Requirements
- R1: After reset, `wr_ready`=1, `tx_empty`=1, `rd_avail`=0, `rd_data`=0, `busy`=0, `overrun`=0 and `ser_out`=0.
- R2: A word is accepted into the transmit FIFO in a cycle with `wr_valid`=1 and `wr_ready`=1; `wr_ready` is 0 exactly when 8 words are waiting, and a word offered then is dropped.
- R3: `rd_data` shows the oldest receive FIFO word and `rd_req`=1 removes it; with the receive FIFO empty `rd_avail`=0, `rd_data` reads 0 and a request changes nothing.
- R4: A frame starts at a clock edge with `bit_tick`=1, `enable`=1, no frame active and a word waiting; the word leaves MSB first on `ser_out`, one bit per later tick, and `ser_in` is sampled at each of those ticks, so feeding `ser_out` back to `ser_in` returns the written word (masked to the frame size). `ser_out` is 0 outside a frame.
- R5: The frame size is `size_m1`+1 bits; values of `size_m1` below 3 give 4 bits. Written bits at or above the frame size are not sent, and a received word holds the frame in its low bits with zeros above.
- R6: With `three_wire`=1, a frame sends bits 7..0 of the word, then samples `size_m1`+1 bits (same lower limit) from `ser_in` while `ser_out` is 0; the received word is stored right-justified.
- R7: With `enable`=0 no new frame starts and both FIFOs keep their contents; a frame already running completes.
- R8: A frame that completes while the receive FIFO holds 8 words is discarded and sets `overrun`, which stays set until reset.
- R9: `busy` is 1 while a frame is active or while `enable`=1 and the transmit FIFO is not empty, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| three_wire | input | 1 | 1 selects the command-then-response frame |
| size_m1 | input | 4 | Frame size minus one (3..15) |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 16 | Word to transmit, right-justified |
| wr_ready | output | 1 | Transmit FIFO has room |
| rd_req | input | 1 | Pop the head of the receive FIFO |
| rd_data | output | 16 | Head of the receive FIFO, 0 when empty |
| rd_avail | output | 1 | Receive FIFO not empty |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO holds 8 words |
| busy | output | 1 | Frame active or work pending |
| overrun | output | 1 | Sticky: a received word was discarded |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
A written word reaches the transmit FIFO at the edge that accepts it, its frame starts at the first tick edge after that, and the received word shows on `rd_avail`/`rd_data` in the cycle after the last tick of the frame: size ticks after the start tick in normal mode, 8 plus size in three-wire mode. Because tick spacing and FIFO depth make those edges hard to pin in a fixed count, the scoreboard does not wait a set number of cycles; its monitor looks at `rd_avail` on every falling edge and compares `rd_data` with the oldest expected word only then. Transmit bits are captured on the falling edge before each tick edge while `busy` is high, which is when the bit under way is stable, and flag checks are taken on falling edges once `busy` has dropped.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int MIN_BITS = 4;
  localparam int CMD_BITS = 8;

  function automatic int eff_bits(input int size_m1);
    return (size_m1 < MIN_BITS - 1) ? MIN_BITS : size_m1 + 1;
  endfunction
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign head  = empty ? '0 : mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/ser_frame_engine.sv
module ser_frame_engine
  import ser_pkg::*;
#(
  parameter int W  = 16,
  localparam int SW = $clog2(W),
  localparam int CW = $clog2(W + CMD_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          three_wire,
  input  logic [SW-1:0] size_m1,
  input  logic          bit_tick,
  input  logic [W-1:0]  tx_word,
  input  logic          tx_avail,
  input  logic          rx_space,
  input  logic          ser_in,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [W-1:0]  rx_word,
  output logic          ser_out,
  output logic          active,
  output logic          overrun
);
  logic [CW-1:0] len_new, tx_len_new, shamt;
  logic [CW-1:0] tx_len_q, rx_first_q, total_q, cnt;
  logic [W-1:0]  shreg, rx_sh;
  logic          in_tx, in_rx, last;

  always_comb begin
    len_new    = CW'(eff_bits(int'(size_m1)));
    tx_len_new = three_wire ? CW'(CMD_BITS) : len_new;
    shamt      = CW'(W) - tx_len_new;
  end

  assign tx_pop  = bit_tick && !active && enable && tx_avail;
  assign in_tx   = cnt < tx_len_q;
  assign in_rx   = cnt >= rx_first_q;
  assign last    = active && bit_tick && (cnt == total_q - 1'b1);
  assign rx_word = {rx_sh[W-2:0], ser_in};
  assign rx_push = last && rx_space;
  assign ser_out = active && in_tx && shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      overrun    <= 1'b0;
      cnt        <= '0;
      tx_len_q   <= '0;
      rx_first_q <= '0;
      total_q    <= '0;
      shreg      <= '0;
      rx_sh      <= '0;
    end else begin
      if (tx_pop) begin
        active     <= 1'b1;
        cnt        <= '0;
        shreg      <= tx_word << shamt;
        rx_sh      <= '0;
        tx_len_q   <= tx_len_new;
        rx_first_q <= three_wire ? CW'(CMD_BITS) : '0;
        total_q    <= three_wire ? CW'(CMD_BITS) + len_new : len_new;
      end else if (active && bit_tick) begin
        if (in_tx) shreg <= shreg << 1;
        if (in_rx) rx_sh <= rx_word;
        cnt <= cnt + 1'b1;
        if (last) active <= 1'b0;
      end
      if (last && !rx_space) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_word_port.sv
module ser_word_port #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int SW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              three_wire,
  input  logic [SW-1:0]     size_m1,
  input  logic              bit_tick,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_avail,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              busy,
  output logic              overrun,
  output logic              ser_out,
  input  logic              ser_in
);
  logic [WORD_W-1:0] tx_head, rx_word;
  logic tx_full, rx_empty, tx_pop, rx_push, eng_active;

  ser_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_valid), .push_data(wr_data),
    .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
  );

  ser_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
    .pop(rd_req), .head(rd_data), .full(rx_full), .empty(rx_empty)
  );

  ser_frame_engine #(.W(WORD_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .three_wire(three_wire),
    .size_m1(size_m1), .bit_tick(bit_tick), .tx_word(tx_head),
    .tx_avail(!tx_empty), .rx_space(!rx_full), .ser_in(ser_in),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .ser_out(ser_out), .active(eng_active), .overrun(overrun)
  );

  assign wr_ready = !tx_full;
  assign rd_avail = !rx_empty;
  assign busy     = eng_active || (enable && !tx_empty);
endmodule

// File: rtl/ser_word_port_chk.sv
module ser_word_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         bit_tick,
  input logic         wr_ready,
  input logic         tx_empty,
  input logic         rd_avail,
  input logic [W-1:0] rd_data,
  input logic         rx_full,
  input logic         busy,
  input logic         overrun,
  input logic         ser_out,
  input logic         eng_active,
  input logic         tx_pop,
  input logic         rx_push
);
  p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !tx_empty);

  p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_avail |-> (rd_data == '0));

  p_start_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (bit_tick && enable && !eng_active));

  p_idle_line_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> !ser_out);

  p_no_start_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !eng_active) |=> !eng_active);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_push);

  p_busy_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> busy);
endmodule

bind ser_word_port ser_word_port_chk #(.W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
  .wr_ready(wr_ready), .tx_empty(tx_empty), .rd_avail(rd_avail),
  .rd_data(rd_data), .rx_full(rx_full), .busy(busy), .overrun(overrun),
  .ser_out(ser_out), .eng_active(eng_active), .tx_pop(tx_pop),
  .rx_push(rx_push)
);

// File: tb/ser_word_port_tb_top.sv
`timescale 1ns/1ps
module ser_word_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, three_wire = 1'b0, bit_tick = 1'b0;
  logic [3:0] size_m1 = 4'd15;
  logic wr_valid = 1'b0, rd_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_ready, rd_avail, tx_empty, rx_full, busy, overrun, ser_out, ser_in;
  logic [15:0] rd_data;
  logic loop_mode = 1'b1, rx_const = 1'b0, mon_on = 1'b0, cap_en = 1'b0;
  logic [31:0] cap = '0;
  logic [15:0] exp_q[$];
  string mon_tag = "R4 loopback";
  int checks = 0, errors = 0, tcnt = 0;

  always #2.5 clk = ~clk;
  assign ser_in = loop_mode ? ser_out : rx_const;

  ser_word_port dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .three_wire(three_wire),
    .size_m1(size_m1), .bit_tick(bit_tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_req(rd_req),
    .rd_data(rd_data), .rd_avail(rd_avail), .tx_empty(tx_empty),
    .rx_full(rx_full), .busy(busy), .overrun(overrun),
    .ser_out(ser_out), .ser_in(ser_in)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-rate tick every 4th cycle; transmit bits captured before each tick edge
  initial forever begin
    @(negedge clk);
    tcnt++;
    bit_tick = (tcnt % 4 == 0);
    if (bit_tick && cap_en && busy) cap = {cap[30:0], ser_out};
  end

  // monitor: pops the receive FIFO and compares against the scoreboard
  initial forever begin
    @(negedge clk);
    rd_req = 1'b0;
    if (mon_on && rd_avail) begin
      if (exp_q.size() == 0) check_eq({mon_tag, " unexpected word"}, {16'h0, rd_data}, 32'hDEAD);
      else check_eq(mon_tag, {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
      rd_req = 1'b1;
    end
  end

  // driver: offers one word and records the expected received word
  task automatic wr(input logic [15:0] w, input logic acc, input logic push, input logic [15:0] rx_exp);
    @(negedge clk);
    check_eq("R2 wr_ready", {31'h0, wr_ready}, {31'h0, acc});
    wr_valid = 1'b1;
    wr_data  = w;
    if (acc && push) exp_q.push_back(rx_exp);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((exp_q.size() != 0 || busy) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) check_eq("R4 drain timeout", 32'h1, 32'h0);
  endtask

  task automatic wait_not_busy();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) check_eq("R9 busy timeout", 32'h1, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 wr_ready", {31'h0, wr_ready}, 32'h1);
    check_eq("R1 tx_empty", {31'h0, tx_empty}, 32'h1);
    check_eq("R1 rd_avail", {31'h0, rd_avail}, 32'h0);
    check_eq("R1 rd_data", {16'h0, rd_data}, 32'h0);
    check_eq("R1 busy", {31'h0, busy}, 32'h0);
    check_eq("R1 overrun", {31'h0, overrun}, 32'h0);
    check_eq("R1 ser_out", {31'h0, ser_out}, 32'h0);

    // R7: pre-fill while disabled, nothing moves
    wr(16'h1234, 1, 1, 16'h1234);
    wr(16'hA5C3, 1, 1, 16'hA5C3);
    wr(16'hFFFF, 1, 1, 16'hFFFF);
    repeat (200) @(negedge clk);
    check_eq("R7 tx kept", {31'h0, tx_empty}, 32'h0);
    check_eq("R7 no frame busy", {31'h0, busy}, 32'h0);
    check_eq("R7 no rx", {31'h0, rd_avail}, 32'h0);
    mon_on = 1'b1;
    mon_tag = "R4 loopback 16-bit";
    enable = 1'b1;
    @(negedge clk);
    check_eq("R9 busy with work", {31'h0, busy}, 32'h1);
    wait_idle();
    @(negedge clk);
    check_eq("R9 busy idle", {31'h0, busy}, 32'h0);

    // R5: sizes, upper bits ignored, right-justified
    mon_tag = "R5 size 8";
    size_m1 = 4'd7;
    wr(16'hBEEF, 1, 1, 16'h00EF);
    wr(16'h1280, 1, 1, 16'h0080);
    wait_idle();
    mon_tag = "R5 size 4";
    size_m1 = 4'd3;
    wr(16'hFFF9, 1, 1, 16'h0009);
    wait_idle();
    mon_tag = "R5 size below 4";
    size_m1 = 4'd1;
    wr(16'h00A6, 1, 1, 16'h0006);
    wait_idle();
    mon_tag = "R5 size 13";
    size_m1 = 4'd12;
    wr(16'hF0F0, 1, 1, 16'h10F0);
    wait_idle();

    // R6: three-wire frame, 8 bits out then 12 bits in
    mon_tag = "R6 three-wire rx";
    loop_mode = 1'b0;
    rx_const = 1'b1;
    three_wire = 1'b1;
    size_m1 = 4'd11;
    cap_en = 1'b1;
    wr(16'hAB5C, 1, 1, 16'h0FFF);
    wait_idle();
    cap_en = 1'b0;
    check_eq("R6 tx byte then low", {11'h0, cap[20:0]}, 32'h0005C000);
    three_wire = 1'b0;
    loop_mode = 1'b1;

    // R2 / R8: full transmit FIFO, then receive overrun
    enable = 1'b0;
    mon_on = 1'b0;
    size_m1 = 4'd3;
    for (int i = 0; i < 8; i++) wr(16'h1230 + 16'(i), 1, 1, 16'(i));
    wr(16'h000F, 0, 0, 16'h0);
    enable = 1'b1;
    wait_not_busy();
    check_eq("R8 rx_full", {31'h0, rx_full}, 32'h1);
    check_eq("R8 no overrun yet", {31'h0, overrun}, 32'h0);
    check_eq("R2 ninth dropped", {31'h0, tx_empty}, 32'h1);
    wr(16'h000F, 1, 0, 16'h0);
    wait_not_busy();
    check_eq("R8 overrun set", {31'h0, overrun}, 32'h1);
    mon_tag = "R8 kept words";
    mon_on = 1'b1;
    wait_idle();
    repeat (3) @(negedge clk);
    check_eq("R3 empty avail", {31'h0, rd_avail}, 32'h0);
    check_eq("R3 empty reads zero", {16'h0, rd_data}, 32'h0);
    check_eq("R8 overrun sticky", {31'h0, overrun}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule